// File: doc/BRIEF.md
# Peripheral Flag and Interrupt Controller

This block sits between a character device and an accumulator processor. It holds the byte most recently received from the device, the byte last written for the device to send, and one ready flag for each direction. It also holds the interrupt enable bit and the interrupt pending bit. The device marks a new byte with a receive strobe and marks a finished transmission with a done strobe. The processor runs an I/O instruction by raising an execute strobe in execute step T3 and presenting the six operation bits of the instruction at the same time. The block then answers in that same cycle with a load-accumulator request, the received byte and a skip request.

The ready flags also act as interrupt sources. When interrupts are enabled and either flag is up, the pending bit is set. This happens only in cycles that the sequencer does not mark as one of the first three fetch steps. The sequencer pulses a clear strobe in the last step of the interrupt cycle, and that strobe clears the enable bit and the pending bit together.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After reset the output-ready flag is 1, and the input-ready flag, the interrupt enable bit and the interrupt pending bit are all 0.
- R2: A receive strobe writes the receive data into the input byte and sets the input-ready flag in the next cycle. This also happens when the flag is already 1, and the new byte overwrites the old one. Without a receive strobe the input byte does not change.
- R3: The input-character operation is op bit 5 (instruction F800 hex). It raises the load request in the same cycle as the execute strobe, with the stored input byte on the byte output. It clears the input-ready flag in the next cycle, unless a receive strobe arrives in the same cycle, in which case the flag stays set.
- R4: The output-character operation is op bit 4 (F400 hex). It copies the low accumulator byte to the output byte and clears the output-ready flag in the next cycle, unless a transmit-done strobe arrives in the same cycle, in which case the flag stays set.
- R5: A transmit-done strobe sets the output-ready flag in the next cycle.
- R6: Skip-on-input is op bit 3 (F200 hex) and skip-on-output is op bit 2 (F100 hex). Each raises the skip request in the same cycle as the execute strobe when its flag currently reads 1. The flag value used is the one held before that cycle's update.
- R7: Interrupt-on is op bit 1 (F080 hex) and sets the enable bit. Interrupt-off is op bit 0 (F040 hex) and clears it. When both bits are given together, the enable bit is cleared.
- R8: The pending bit becomes 1 in the next cycle when the fetch-phase input is low, the enable bit is 1 and at least one ready flag is 1. It never becomes set from a cycle in which the fetch-phase input is high.
- R9: The interrupt-cycle clear strobe clears both the enable bit and the pending bit in the next cycle. It overrides any set in the same cycle.
- R10: When the execute strobe is low, the op bits have no effect on the flags, on the enable bit, on the output byte or on the request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_rx_stb | input | 1 | Device delivered a byte |
| dev_rx_data | input | 8 | Byte delivered by the device |
| dev_tx_done | input | 1 | Device finished sending the output byte |
| io_exec | input | 1 | I/O instruction executing (step T3) |
| io_op | input | 6 | Instruction bits 11..6: [5] input char, [4] output char, [3] skip in, [2] skip out, [1] int on, [0] int off |
| ac_lo | input | 8 | Low accumulator byte |
| fetch_phase | input | 1 | Sequencer is in fetch step T0, T1 or T2 |
| irq_clr | input | 1 | Last step of the interrupt cycle |
| ld_ac_req | output | 1 | Load the accumulator low byte from in_byte |
| in_byte | output | 8 | Stored input byte |
| skip_req | output | 1 | Increment the program counter |
| out_byte | output | 8 | Stored output byte for the device |
| in_flag | output | 1 | Input-ready flag |
| out_flag | output | 1 | Output-ready flag |
| int_en | output | 1 | Interrupt enable bit |
| int_pend | output | 1 | Interrupt pending bit |

## Verification
The random part of the bench drives random op fields, with the device strobes, the fetch-phase input and the clear strobe each held at a moderate rate. Under that mix, the flag collisions and the pending-bit windows occur on their own many times. A bench model then checks every output on every cycle. Directed sequences force four cases: a receive strobe landing on a set flag, device strobes colliding with the processor operations that clear the same flags, interrupt-on and interrupt-off given together, and a clear strobe arriving while the set condition holds. These sequences separate device-over-processor priority from plain ordering. A run with the execute strobe low and every op bit high shows that the op field is ignored. Holding the fetch-phase input high while the set condition is true shows that the sampling window is honoured.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int OP_W = 6;

    typedef struct packed {
        logic get_char;
        logic put_char;
        logic skip_in;
        logic skip_out;
        logic irq_on;
        logic irq_off;
    } io_cmd_t;

    function automatic io_cmd_t decode_op(input logic exec, input logic [OP_W-1:0] op);
        io_cmd_t c;
        c.get_char = exec & op[5];
        c.put_char = exec & op[4];
        c.skip_in  = exec & op[3];
        c.skip_out = exec & op[2];
        c.irq_on   = exec & op[1];
        c.irq_off  = exec & op[0];
        return c;
    endfunction

endpackage

// File: rtl/pio_in_chan.sv
module pio_in_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            flag <= 1'b0;
        end else begin
            if (rx_stb) data <= rx_data;
            if (rx_stb)    flag <= 1'b1;  // device side wins
            else if (take) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pio_out_chan.sv
module pio_out_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_done,
    input  logic              put,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data,
    output logic              flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            flag <= 1'b1;
        end else begin
            if (put) data <= wdata;
            if (tx_done)  flag <= 1'b1;  // device side wins
            else if (put) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit (
    input  logic clk,
    input  logic rst,
    input  logic en_set,
    input  logic en_clr,
    input  logic cyc_clr,
    input  logic fetch_phase,
    input  logic src_any,
    output logic ien,
    output logic pend
);
    logic arm;
    assign arm = ~fetch_phase & ien & src_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= 1'b0;
            pend <= 1'b0;
        end else if (cyc_clr) begin
            ien  <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (en_clr)      ien <= 1'b0;
            else if (en_set) ien <= 1'b1;
            if (arm) pend <= 1'b1;
        end
    end
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_rx_stb,
    input  logic [DATA_W-1:0] dev_rx_data,
    input  logic              dev_tx_done,
    input  logic              io_exec,
    input  logic [OP_W-1:0]   io_op,
    input  logic [DATA_W-1:0] ac_lo,
    input  logic              fetch_phase,
    input  logic              irq_clr,
    output logic              ld_ac_req,
    output logic [DATA_W-1:0] in_byte,
    output logic              skip_req,
    output logic [DATA_W-1:0] out_byte,
    output logic              in_flag,
    output logic              out_flag,
    output logic              int_en,
    output logic              int_pend
);
    io_cmd_t cmd;
    assign cmd = decode_op(io_exec, io_op);

    pio_in_chan #(.DATA_W(DATA_W)) in_u (
        .clk(clk), .rst(rst), .rx_stb(dev_rx_stb), .rx_data(dev_rx_data),
        .take(cmd.get_char), .data(in_byte), .flag(in_flag)
    );

    pio_out_chan #(.DATA_W(DATA_W)) out_u (
        .clk(clk), .rst(rst), .tx_done(dev_tx_done), .put(cmd.put_char),
        .wdata(ac_lo), .data(out_byte), .flag(out_flag)
    );

    pio_irq_unit irq_u (
        .clk(clk), .rst(rst), .en_set(cmd.irq_on), .en_clr(cmd.irq_off),
        .cyc_clr(irq_clr), .fetch_phase(fetch_phase),
        .src_any(in_flag | out_flag), .ien(int_en), .pend(int_pend)
    );

    assign ld_ac_req = cmd.get_char;
    assign skip_req  = (cmd.skip_in & in_flag) | (cmd.skip_out & out_flag);
endmodule

// File: rtl/pio_irq_ctrl_chk.sv
module pio_irq_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_rx_stb,
    input logic [DATA_W-1:0] dev_rx_data,
    input logic              dev_tx_done,
    input logic              io_exec,
    input logic [5:0]        io_op,
    input logic [DATA_W-1:0] ac_lo,
    input logic              fetch_phase,
    input logic              irq_clr,
    input logic [DATA_W-1:0] in_byte,
    input logic [DATA_W-1:0] out_byte,
    input logic              in_flag,
    input logic              out_flag,
    input logic              int_en,
    input logic              int_pend
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_flag && !in_flag && !int_en && !int_pend));

    a_r2_rx_load: assert property (@(posedge clk) disable iff (rst)
        dev_rx_stb |=> (in_flag && in_byte == $past(dev_rx_data)));

    a_r2_hold_byte: assert property (@(posedge clk) disable iff (rst)
        !dev_rx_stb |=> $stable(in_byte));

    a_r3_get_clears: assert property (@(posedge clk) disable iff (rst)
        (io_exec && io_op[5] && !dev_rx_stb) |=> !in_flag);

    a_r4_put_loads: assert property (@(posedge clk) disable iff (rst)
        (io_exec && io_op[4] && !dev_tx_done) |=> (!out_flag && out_byte == $past(ac_lo)));

    a_r5_tx_sets: assert property (@(posedge clk) disable iff (rst)
        dev_tx_done |=> out_flag);

    a_r7_irq_on: assert property (@(posedge clk) disable iff (rst)
        (io_exec && io_op[1] && !io_op[0] && !irq_clr) |=> int_en);

    a_r8_arm: assert property (@(posedge clk) disable iff (rst)
        (!fetch_phase && int_en && (in_flag || out_flag) && !irq_clr) |=> int_pend);

    a_r8_fetch_block: assert property (@(posedge clk) disable iff (rst)
        (fetch_phase && !int_pend) |=> !int_pend);

    a_r9_cycle_clear: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> (!int_en && !int_pend));

    a_r10_idle_flags: assert property (@(posedge clk) disable iff (rst)
        (!io_exec && !irq_clr && !dev_rx_stb && !dev_tx_done) |=>
            ($stable(in_flag) && $stable(out_flag) && $stable(int_en) && $stable(out_byte)));
endmodule

bind pio_irq_ctrl pio_irq_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .dev_rx_stb(dev_rx_stb), .dev_rx_data(dev_rx_data),
    .dev_tx_done(dev_tx_done), .io_exec(io_exec), .io_op(io_op), .ac_lo(ac_lo),
    .fetch_phase(fetch_phase), .irq_clr(irq_clr), .in_byte(in_byte),
    .out_byte(out_byte), .in_flag(in_flag), .out_flag(out_flag),
    .int_en(int_en), .int_pend(int_pend)
);

// File: tb/pio_irq_ctrl_tb_top.sv
module pio_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_rx_stb = 1'b0;
    logic [7:0] dev_rx_data = '0;
    logic       dev_tx_done = 1'b0;
    logic       io_exec = 1'b0;
    logic [5:0] io_op = '0;
    logic [7:0] ac_lo = '0;
    logic       fetch_phase = 1'b0;
    logic       irq_clr = 1'b0;
    logic       ld_ac_req, skip_req, in_flag, out_flag, int_en, int_pend;
    logic [7:0] in_byte, out_byte;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model state
    logic [7:0] m_inb, m_outb;
    logic       m_fgi, m_fgo, m_ien, m_pend;

    always #2.5 clk = ~clk;

    pio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .dev_rx_stb(dev_rx_stb), .dev_rx_data(dev_rx_data),
        .dev_tx_done(dev_tx_done), .io_exec(io_exec), .io_op(io_op), .ac_lo(ac_lo),
        .fetch_phase(fetch_phase), .irq_clr(irq_clr), .ld_ac_req(ld_ac_req),
        .in_byte(in_byte), .skip_req(skip_req), .out_byte(out_byte),
        .in_flag(in_flag), .out_flag(out_flag), .int_en(int_en), .int_pend(int_pend)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_skip();
        return io_exec & ((io_op[3] & m_fgi) | (io_op[2] & m_fgo));
    endfunction

    function automatic logic exp_ld();
        return io_exec & io_op[5];
    endfunction

    task automatic model_reset();
        m_inb = '0; m_outb = '0; m_fgi = 0; m_fgo = 1; m_ien = 0; m_pend = 0;
    endtask

    task automatic model_step();
        logic n_pend, n_ien;
        n_pend = irq_clr ? 1'b0 : ((!fetch_phase && m_ien && (m_fgi || m_fgo)) ? 1'b1 : m_pend);
        n_ien  = irq_clr ? 1'b0 : (io_exec && io_op[0]) ? 1'b0 : (io_exec && io_op[1]) ? 1'b1 : m_ien;
        if (dev_rx_stb) m_inb = dev_rx_data;
        if (dev_rx_stb) m_fgi = 1'b1; else if (io_exec && io_op[5]) m_fgi = 1'b0;
        if (io_exec && io_op[4]) m_outb = ac_lo;
        if (dev_tx_done) m_fgo = 1'b1; else if (io_exec && io_op[4]) m_fgo = 1'b0;
        m_ien = n_ien; m_pend = n_pend;
    endtask

    task automatic check_state();
        check("R2", "in_byte", in_byte, m_inb);
        check("R3", "in_flag", {7'b0, in_flag}, {7'b0, m_fgi});
        check("R4", "out_byte", out_byte, m_outb);
        check("R5", "out_flag", {7'b0, out_flag}, {7'b0, m_fgo});
        check("R7", "int_en", {7'b0, int_en}, {7'b0, m_ien});
        check("R8", "int_pend", {7'b0, int_pend}, {7'b0, m_pend});
    endtask

    // inputs are already driven (at negedge); check combinational outputs, take edge, check state
    task automatic cycle();
        #1;
        check("R3", "ld_ac_req", {7'b0, ld_ac_req}, {7'b0, exp_ld()});
        check("R6", "skip_req", {7'b0, skip_req}, {7'b0, exp_skip()});
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_state();
    endtask

    task automatic drive(input logic rx, input logic [7:0] d, input logic tx,
                         input logic ex, input logic [5:0] op, input logic [7:0] ac,
                         input logic fp, input logic clr);
        dev_rx_stb = rx; dev_rx_data = d; dev_tx_done = tx; io_exec = ex;
        io_op = op; ac_lo = ac; fetch_phase = fp; irq_clr = clr;
    endtask

    task automatic idle();
        drive(0, 8'h00, 0, 0, 6'h00, 8'h00, 1, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        check("R1", "out_flag", {7'b0, out_flag}, 8'h01);
        check("R1", "in_flag",  {7'b0, in_flag},  8'h00);
        check("R1", "int_en",   {7'b0, int_en},   8'h00);
        check("R1", "int_pend", {7'b0, int_pend}, 8'h00);

        // R8: fetch phase blocks arming even with IEN and a flag set
        drive(0, 0, 0, 1, 6'b000010, 0, 1, 0); cycle();          // ION
        idle(); cycle(); cycle();
        check("R8", "int_pend fetch", {7'b0, int_pend}, 8'h00);
        drive(0, 0, 0, 0, 6'h00, 0, 0, 0); cycle();
        check("R8", "int_pend armed", {7'b0, int_pend}, 8'h01);
        // R9: clear while arming condition holds
        drive(0, 0, 0, 0, 6'h00, 0, 0, 1); cycle();
        check("R9", "int_en", {7'b0, int_en}, 8'h00);
        check("R9", "int_pend", {7'b0, int_pend}, 8'h00);

        // R2: overwrite while flag set
        drive(1, 8'hA5, 0, 0, 6'h00, 0, 1, 0); cycle();
        drive(1, 8'h3C, 0, 0, 6'h00, 0, 1, 0); cycle();
        check("R2", "overwrite byte", in_byte, 8'h3C);
        check("R2", "flag kept", {7'b0, in_flag}, 8'h01);
        // R3 collision: rx strobe with input char, device wins
        drive(1, 8'h77, 0, 1, 6'b100000, 0, 1, 0); cycle();
        check("R3", "flag kept on collision", {7'b0, in_flag}, 8'h01);
        drive(0, 0, 0, 1, 6'b100000, 0, 1, 0); cycle();
        check("R3", "flag cleared", {7'b0, in_flag}, 8'h00);
        // R4 collision: tx done with output char
        drive(0, 0, 1, 1, 6'b010000, 8'h5A, 1, 0); cycle();
        check("R4", "out_byte", out_byte, 8'h5A);
        check("R4", "flag kept on collision", {7'b0, out_flag}, 8'h01);
        // R7: both on and off
        drive(0, 0, 0, 1, 6'b000011, 0, 1, 0); cycle();
        check("R7", "both clear", {7'b0, int_en}, 8'h00);
        // R10: op ignored without exec
        drive(0, 0, 0, 0, 6'b111111, 8'hFF, 1, 0); cycle();
        check("R10", "in_flag", {7'b0, in_flag}, 8'h00);
        check("R10", "out_flag", {7'b0, out_flag}, 8'h01);
        check("R10", "out_byte", out_byte, 8'h5A);
        check("R10", "int_en", {7'b0, int_en}, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 5) == 0, 8'($urandom), ($urandom % 6) == 0,
                  ($urandom % 2) == 0, 6'($urandom), 8'($urandom),
                  ($urandom % 2) == 0, ($urandom % 12) == 0);
            cycle();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule